// File: doc/BRIEF.md
# Eight-Point Radix-2 FFT Engine

This block computes the complex discrete Fourier transform of eight fixed-point samples, X(k) = sum over n of x(n)·e^(−j2πnk/8). A caller pulses `start`, streams eight complex samples in natural order n = 0..7 under `in_valid`, and waits for the one-cycle `done` pulse. The eight bins can then be read back in natural order through the `rd_idx` port. The results stay in place until the next `start`.

While samples are loaded, each one is written to the slot at the bit-reversed position of its index. A single shared radix-2 butterfly then works through three decimation-in-time stages, one butterfly per cycle, four per stage. Each butterfly uses one complex product W·b and forms a + W·b and a − W·b. One twiddle from a four-entry table of W8^0..W8^3 serves both outputs because W^(k+4) = −W^k. First-stage butterflies always use W^0 = 1. An optional halving after every stage keeps full-scale inputs inside the data width, which gives an overall gain of 1/8.

The sequencer has four states:
- **IDLE**: results are held. `start` moves it to **LOAD**.
- **LOAD**: the eighth accepted sample moves it to **CALC**.
- **CALC**: the twelfth butterfly moves it to **DONE**.
- **DONE**: lasts one cycle and always returns to **IDLE**.

Top module: `fft8_engine`

## Requirements
- R1: While `rst_n` is low and after its release, `busy` and `done` are 0, and every bin read through `rd_idx` returns 0 until a transform completes.
- R2: In LOAD, a sample is taken only on a cycle with `in_valid` = 1. Samples are numbered n = 0..7 in arrival order, and cycles with `in_valid` = 0 are skipped without effect. `in_valid` outside LOAD is ignored.
- R3: With `scale_en` = 0, the value on `rd_re`/`rd_im` for `rd_idx` = k is X(k) within ±6 LSB. Data are two's complement, with `in_re`/`rd_re` the real part and `in_im`/`rd_im` the imaginary part.
- R4: With `scale_en` = 1 (sampled together with `start`), every stage halves its outputs, so each bin equals X(k)/8 within ±6 LSB.
- R5: `start` in IDLE sets `busy` from the next cycle. After the edge that takes the eighth sample, `done` is 1 exactly in the cycle after the twelfth following rising edge, and only for that one cycle. `busy` is 0 while `done` is 1.
- R6: `start` while `busy` is 1 has no effect on the sample count, the timing or the results.
- R7: Outside LOAD and CALC, the bins read through `rd_idx` do not change until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new transform (taken in IDLE only) |
| scale_en | input | 1 | Halve after each stage; captured with `start` |
| in_valid | input | 1 | A sample is present on `in_re`/`in_im` |
| in_re | input | DW | Sample real part |
| in_im | input | DW | Sample imaginary part |
| busy | output | 1 | Loading or computing |
| done | output | 1 | One-cycle pulse when all bins are valid |
| rd_idx | input | 3 | Bin index k to read |
| rd_re | output | DW | Real part of bin k |
| rd_im | output | DW | Imaginary part of bin k |

## Verification
The bench applies an impulse at each of the eight positions, because every bin then has unit magnitude and a phase that rotates with the position. An engine that loaded samples in natural rather than bit-reversed order would put the wrong phases into most bins. Complex tones at each of the eight frequencies must land all of their energy in a single bin. A twiddle entry with a wrong sign, or a butterfly that pairs the wrong slots, moves that energy into a neighbouring or mirror bin. Constant and tone inputs are run with and without per-stage halving: a halving step that is missing or doubled gives results off by a factor of two, or wrapped values. A `start` pulse inside load and compute, a gap in `in_valid`, and a readback after idle cycles expose a sequencer that restarts, drops or miscounts samples, or corrupts results while idle.

// File: rtl/fft8_pkg.sv
package fft8_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_CALC = 2'd2,
        ST_DONE = 2'd3
    } fft8_state_e;

    function automatic logic [2:0] fft8_bitrev(input logic [2:0] idx);
        return {idx[0], idx[1], idx[2]};
    endfunction

endpackage

// File: rtl/fft8_twiddle.sv
module fft8_twiddle #(
    parameter int TW = 16
) (
    input  logic [1:0]           k,
    output logic signed [TW-1:0] w_re,
    output logic signed [TW-1:0] w_im
);
    // Unity is 2^(TW-2); the diagonal value is unity * sqrt(0.5), rounded.
    localparam int                   ONE_I = 1 << (TW - 2);
    localparam logic signed [TW-1:0] ONE   = TW'(ONE_I);
    localparam logic signed [TW-1:0] DIAG  = TW'($rtoi(real'(ONE_I) * 0.7071067811865476 + 0.5));

    // Entries hold cos(2*pi*k/8) and -sin(2*pi*k/8) for k = 0..3.
    always_comb begin
        unique case (k)
            2'd0: begin w_re = ONE;   w_im = '0;    end
            2'd1: begin w_re = DIAG;  w_im = -DIAG; end
            2'd2: begin w_re = '0;    w_im = -ONE;  end
            2'd3: begin w_re = -DIAG; w_im = -DIAG; end
        endcase
    end
endmodule

// File: rtl/fft8_bfly.sv
module fft8_bfly #(
    parameter int DW = 16,
    parameter int TW = 16
) (
    input  logic                 scale,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic signed [TW-1:0] w_re,
    input  logic signed [TW-1:0] w_im,
    output logic signed [DW-1:0] x_re,
    output logic signed [DW-1:0] x_im,
    output logic signed [DW-1:0] y_re,
    output logic signed [DW-1:0] y_im
);
    localparam int PW = DW + TW;   // full product width
    localparam int FR = TW - 2;    // twiddle fraction bits

    logic signed [PW-1:0] m_rr, m_ii, m_ri, m_ir;
    logic signed [DW:0]   p_re, p_im;
    logic signed [DW+1:0] s_xr, s_xi, s_yr, s_yi;

    assign m_rr = PW'(w_re) * PW'(b_re);
    assign m_ii = PW'(w_im) * PW'(b_im);
    assign m_ri = PW'(w_re) * PW'(b_im);
    assign m_ir = PW'(w_im) * PW'(b_re);

    // Complex product W*b, back to the data scale (one growth bit kept).
    assign p_re = (DW+1)'((m_rr - m_ii) >>> FR);
    assign p_im = (DW+1)'((m_ri + m_ir) >>> FR);

    // The mirrored twiddle W^(k+4) = -W^k gives the lower output by subtraction.
    assign s_xr = (DW+2)'(a_re) + (DW+2)'(p_re);
    assign s_xi = (DW+2)'(a_im) + (DW+2)'(p_im);
    assign s_yr = (DW+2)'(a_re) - (DW+2)'(p_re);
    assign s_yi = (DW+2)'(a_im) - (DW+2)'(p_im);

    assign x_re = scale ? DW'(s_xr >>> 1) : DW'(s_xr);
    assign x_im = scale ? DW'(s_xi >>> 1) : DW'(s_xi);
    assign y_re = scale ? DW'(s_yr >>> 1) : DW'(s_yr);
    assign y_im = scale ? DW'(s_yi >>> 1) : DW'(s_yi);
endmodule

// File: rtl/fft8_engine.sv
module fft8_engine
    import fft8_pkg::*;
#(
    parameter int DW = 16,
    parameter int TW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 scale_en,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    output logic                 busy,
    output logic                 done,
    input  logic [2:0]           rd_idx,
    output logic signed [DW-1:0] rd_re,
    output logic signed [DW-1:0] rd_im
);
    localparam int NPT   = 8;
    localparam int LOGN  = $clog2(NPT);
    localparam int NBF   = NPT / 2;
    localparam int NSTEP = LOGN * NBF;
    localparam int CW    = $clog2(NSTEP);

    fft8_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          scale_q;

    logic signed [DW-1:0] mem_re [NPT];
    logic signed [DW-1:0] mem_im [NPT];

    logic [1:0]           stg, bfi, tw_k;
    logic [LOGN-1:0]      top, bot;
    logic signed [TW-1:0] w_re, w_im;
    logic signed [DW-1:0] x_re, x_im, y_re, y_im;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LOAD;
            ST_LOAD: if (in_valid && cnt_q == CW'(NPT - 1)) state_d = ST_CALC;
            ST_CALC: if (cnt_q == CW'(NSTEP - 1)) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOAD: busy = 1'b1;
            ST_CALC: busy = 1'b1;
            ST_DONE: done = 1'b1;
        endcase
    end

    // Sample / butterfly counter and scale capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            scale_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (start) scale_q <= scale_en;
                end
                ST_LOAD: if (in_valid) cnt_q <= (cnt_q == CW'(NPT - 1)) ? '0 : cnt_q + 1'b1;
                ST_CALC: cnt_q <= (cnt_q == CW'(NSTEP - 1)) ? '0 : cnt_q + 1'b1;
                ST_DONE: cnt_q <= '0;
            endcase
        end
    end

    // Butterfly addressing: stage in the upper counter bits, butterfly in the lower.
    assign stg = cnt_q[CW-1:2];
    assign bfi = cnt_q[1:0];

    always_comb begin
        unique case (stg)
            2'd0: begin top = {bfi, 1'b0};              bot = {bfi, 1'b1};              tw_k = 2'd0;          end
            2'd1: begin top = {bfi[1], 1'b0, bfi[0]};   bot = {bfi[1], 1'b1, bfi[0]};   tw_k = {bfi[0], 1'b0}; end
            2'd2: begin top = {1'b0, bfi};              bot = {1'b1, bfi};              tw_k = bfi;           end
            2'd3: begin top = '0;                       bot = '0;                       tw_k = 2'd0;          end
        endcase
    end

    fft8_twiddle #(.TW(TW)) u_tw (
        .k    (tw_k),
        .w_re (w_re),
        .w_im (w_im)
    );

    fft8_bfly #(.DW(DW), .TW(TW)) u_bfly (
        .scale (scale_q),
        .a_re  (mem_re[top]),
        .a_im  (mem_im[top]),
        .b_re  (mem_re[bot]),
        .b_im  (mem_im[bot]),
        .w_re  (w_re),
        .w_im  (w_im),
        .x_re  (x_re),
        .x_im  (x_im),
        .y_re  (y_re),
        .y_im  (y_im)
    );

    // In-place sample store: bit-reversed writes while loading, butterfly writes while computing.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPT; i++) begin
                mem_re[i] <= '0;
                mem_im[i] <= '0;
            end
        end else if (state_q == ST_LOAD && in_valid) begin
            mem_re[fft8_bitrev(cnt_q[LOGN-1:0])] <= in_re;
            mem_im[fft8_bitrev(cnt_q[LOGN-1:0])] <= in_im;
        end else if (state_q == ST_CALC) begin
            mem_re[top] <= x_re;
            mem_im[top] <= x_im;
            mem_re[bot] <= y_re;
            mem_im[bot] <= y_im;
        end
    end

    assign rd_re = mem_re[rd_idx];
    assign rd_im = mem_im[rd_idx];
endmodule

// File: rtl/fft8_engine_chk.sv
module fft8_engine_chk #(
    parameter int DW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic [2:0]           rd_idx,
    input logic signed [DW-1:0] rd_re,
    input logic signed [DW-1:0] rd_im
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done));

    p_start_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && start) |=> busy);

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    p_start_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && $past(!busy && !done) && $stable(rd_idx))
            |-> ($stable(rd_re) && $stable(rd_im)));
endmodule

bind fft8_engine fft8_engine_chk #(.DW(DW)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .rd_idx (rd_idx),
    .rd_re  (rd_re),
    .rd_im  (rd_im)
);

// File: tb/fft8_engine_tb_top.sv
`timescale 1ns/1ps
module fft8_engine_tb_top;
    localparam int DW  = 16;
    localparam int TOL = 6;
    localparam real PI = 3.14159265358979323846;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic                 scale_en = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_re = '0;
    logic signed [DW-1:0] in_im = '0;
    logic                 busy, done;
    logic [2:0]           rd_idx = '0;
    logic signed [DW-1:0] rd_re, rd_im;

    int checks = 0;
    int errors = 0;
    int xr [8];
    int xi [8];
    int held_re [8];
    int held_im [8];

    always #10 clk = ~clk;

    fft8_engine #(.DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .scale_en(scale_en),
        .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .busy(busy), .done(done),
        .rd_idx(rd_idx), .rd_re(rd_re), .rd_im(rd_im)
    );

    task automatic check_int(input string req, input string what, input int got, input int exp, input int tol);
        int d;
        checks++;
        d = got - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (tol %0d)", req, what, got, exp, tol);
        end
    endtask

    function automatic int rnd(input real v);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    // Compare every bin against the direct DFT of xr/xi.
    task automatic check_bins(input string req, input bit scl);
        real er, ei, th, g;
        g = scl ? 0.125 : 1.0;
        for (int k = 0; k < 8; k++) begin
            er = 0.0; ei = 0.0;
            for (int n = 0; n < 8; n++) begin
                th = 2.0 * PI * real'(n * k) / 8.0;
                er += real'(xr[n]) * $cos(th) + real'(xi[n]) * $sin(th);
                ei += real'(xi[n]) * $cos(th) - real'(xr[n]) * $sin(th);
            end
            @(negedge clk);
            rd_idx = 3'(k);
            #1;
            check_int(req, $sformatf("bin %0d re", k), int'(rd_re), rnd(er * g), TOL);
            check_int(req, $sformatf("bin %0d im", k), int'(rd_im), rnd(ei * g), TOL);
        end
    endtask

    // Load xr/xi with a gap after sample 3; optionally pulse start while busy (R6).
    task automatic run_fft(input bit scl, input bit poke);
        @(negedge clk);
        start = 1'b1; scale_en = scl;
        @(negedge clk);
        start = 1'b0; scale_en = ~scl;
        check_int("R5", "busy after start", int'(busy), 1, 0);
        for (int n = 0; n < 8; n++) begin
            if (n == 4) begin
                in_valid = 1'b0; in_re = 16'sd777; in_im = -16'sd777;
                start = poke;
                @(negedge clk);
                start = 1'b0;
            end
            in_valid = 1'b1;
            in_re = DW'(xr[n]);
            in_im = DW'(xi[n]);
            @(negedge clk);
        end
        in_valid = 1'b0; in_re = 16'sd1234; in_im = 16'sd4321;
        for (int c = 1; c <= 11; c++) begin
            if (poke && c == 5) start = 1'b1;
            if (c == 6) start = 1'b0;
            @(negedge clk);
        end
        check_int("R5", "done before 12th edge", int'(done), 0, 0);
        check_int(poke ? "R6" : "R5", "busy before done", int'(busy), 1, 0);
        @(negedge clk);
        check_int("R5", "done at 12th edge", int'(done), 1, 0);
        check_int("R5", "busy while done", int'(busy), 0, 0);
        @(negedge clk);
        check_int("R5", "done one cycle", int'(done), 0, 0);
        check_int("R5", "busy after done", int'(busy), 0, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        // R1: reset state
        repeat (3) @(negedge clk);
        check_int("R1", "busy in reset", int'(busy), 0, 0);
        check_int("R1", "done in reset", int'(done), 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_int("R1", "busy after reset", int'(busy), 0, 0);
        for (int k = 0; k < 8; k++) begin
            rd_idx = 3'(k); #1;
            check_int("R1", "bin re after reset", int'(rd_re), 0, 0);
            check_int("R1", "bin im after reset", int'(rd_im), 0, 0);
        end

        // R2 and R3: impulse at each position, unscaled
        for (int p = 0; p < 8; p++) begin
            for (int n = 0; n < 8; n++) begin xr[n] = (n == p) ? 1000 : 0; xi[n] = 0; end
            run_fft(1'b0, 1'b0);
            check_bins("R2", 1'b0);
        end

        // R4: imaginary impulse at each position, scaled
        for (int p = 0; p < 8; p++) begin
            for (int n = 0; n < 8; n++) begin xr[n] = 0; xi[n] = (n == p) ? 8000 : 0; end
            run_fft(1'b1, 1'b0);
            check_bins("R4", 1'b1);
        end

        // R3: constant, unscaled; R4: constant, scaled
        for (int n = 0; n < 8; n++) begin xr[n] = 1000; xi[n] = -500; end
        run_fft(1'b0, 1'b0);
        check_bins("R3", 1'b0);
        for (int n = 0; n < 8; n++) begin xr[n] = 16000; xi[n] = 16000; end
        run_fft(1'b1, 1'b0);
        check_bins("R4", 1'b1);

        // R3: complex tone at every frequency, unscaled
        for (int f = 0; f < 8; f++) begin
            for (int n = 0; n < 8; n++) begin
                xr[n] = rnd(900.0 * $cos(2.0 * PI * real'(f * n) / 8.0));
                xi[n] = rnd(900.0 * $sin(2.0 * PI * real'(f * n) / 8.0));
            end
            run_fft(1'b0, 1'b0);
            check_bins("R3", 1'b0);
        end

        // R4: complex tone at every frequency, scaled
        for (int f = 0; f < 8; f++) begin
            for (int n = 0; n < 8; n++) begin
                xr[n] = rnd(12000.0 * $cos(2.0 * PI * real'(f * n) / 8.0));
                xi[n] = rnd(-12000.0 * $sin(2.0 * PI * real'(f * n) / 8.0));
            end
            run_fft(1'b1, 1'b0);
            check_bins("R4", 1'b1);
        end

        // R6: start pulses during load and compute
        for (int n = 0; n < 8; n++) begin xr[n] = 300 * n - 1000; xi[n] = 700 - 150 * n; end
        run_fft(1'b0, 1'b1);
        check_bins("R6", 1'b0);

        // R7 and R2: results held through idle cycles with in_valid toggling
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); rd_idx = 3'(k); #1;
            held_re[k] = int'(rd_re); held_im[k] = int'(rd_im);
        end
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            in_valid = c[0]; in_re = DW'(c * 97); in_im = DW'(-c * 31);
        end
        in_valid = 1'b0;
        check_int("R7", "busy in idle", int'(busy), 0, 0);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); rd_idx = 3'(k); #1;
            check_int("R7", "held re", int'(rd_re), held_re[k], 0);
            check_int("R7", "held im", int'(rd_im), held_im[k], 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule